// File: doc/BRIEF.md
# Serial-clocked memory transaction sequencer

This block sequences one transaction of a small serial-slave memory. It runs on the serial clock and watches an active-low select line. It also sees the single bit that currently sits at the low end of the external receive shift register. It does not move data itself. It produces four one-cycle or windowed enables that steer the logic around it: the address latch, the memory array write port, the parallel load of the transmit shift register, and the output buffer of the serial data-out pin.

A transaction opens with a command byte. The upper seven bits form the address and the final bit chooses the direction, with 1 meaning read. A write then takes one more byte and commits it to memory. A read loads the addressed word into the shift register in one state and then enables the output buffer for a full word in the next state. After either path the block goes idle until select is released. Releasing select at any point aborts the transaction, and the next selection starts a new command.

Top module: `spi_mem_seq`

Edges are counted from the first rising serial-clock edge with `cs_n` low (edge 1). "The cycle after edge k" is the interval between rising edges k and k+1.

## Requirements
- R1: While `cs_n` is high, all four enables are low in the same cycle, without waiting for a clock edge.
- R2: `addr_we` is high during the cycle after edge 8 only, for exactly one cycle per transaction.
- R3: The value of `ser_bit` at edge 9 selects the direction: 1 takes the read path and 0 takes the write path. The value of `ser_bit` at any other edge has no effect on the enables.
- R4: On the write path, `mem_we` is high during the cycle after edge 16 only. `sr_load` and `miso_oe` stay low for the whole transaction.
- R5: On the read path, `sr_load` is high during the cycle after edge 9 only, and `mem_we` stays low for the whole transaction.
- R6: On the read path, `miso_oe` is high during the cycles after edges 10 through 17, which is exactly 8 consecutive cycles.
- R7: Once a path completes (after edge 17 for a write, after edge 18 for a read), all enables stay low on every further edge until `cs_n` rises.
- R8: Raising `cs_n` after any number of edges aborts the transaction. The next selection again asserts `addr_we` after exactly 8 edges.
- R9: At most one of the four enables is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock; all state changes on its rising edge |
| cs_n | input | 1 | Active-low select; high aborts and idles the block |
| ser_bit | input | 1 | Bit at the low end of the receive shift register |
| miso_oe | output | 1 | Output buffer enable for the serial data-out pin |
| mem_we | output | 1 | Memory array write enable |
| addr_we | output | 1 | Address latch write enable |
| sr_load | output | 1 | Transmit shift register parallel-load enable |

## Verification
Both directions are run against every possible abort point from 1 to 24 edges. This separates a correct command count from an off-by-one count, and a clean abort from leftover state that would shift the next transaction. Each run is repeated under several `ser_bit` patterns: all zeros, all ones, alternating bits, and an irregular word. Every pattern is forced to the direction value at edge 9 only. If any other edge's bit affected the direction or timing, the result would differ between patterns. Runs long enough to pass the end of a path check that the idle phase ignores further clocks and data.

// File: rtl/spi_mem_seq_pkg.sv
package spi_mem_seq_pkg;
   localparam int NUM_ST   = 6;
   localparam int IX_START = 0;
   localparam int IX_RECV  = 1;
   localparam int IX_WRITE = 2;
   localparam int IX_READ0 = 3;
   localparam int IX_READ1 = 4;
   localparam int IX_END   = 5;

   typedef logic [NUM_ST-1:0] st_vec_t;

   localparam st_vec_t ST_START = st_vec_t'(1) << IX_START;
   localparam st_vec_t ST_RECV  = st_vec_t'(1) << IX_RECV;
   localparam st_vec_t ST_WRITE = st_vec_t'(1) << IX_WRITE;
   localparam st_vec_t ST_READ0 = st_vec_t'(1) << IX_READ0;
   localparam st_vec_t ST_READ1 = st_vec_t'(1) << IX_READ1;
   localparam st_vec_t ST_END   = st_vec_t'(1) << IX_END;
endpackage

// File: rtl/seq_state_reg.sv
module seq_state_reg
   import spi_mem_seq_pkg::*;
(
   input  logic    sclk,
   input  logic    cs_n,
   input  st_vec_t st_d,
   output st_vec_t st_q
);
   for (genvar i = 0; i < NUM_ST; i++) begin : g_bit
      localparam logic IDLE_V = (i == IX_START);
      always_ff @(posedge sclk) begin
         if (cs_n) st_q[i] <= IDLE_V;
         else      st_q[i] <= st_d[i];
      end
   end
endmodule

// File: rtl/seq_bit_counter.sv
module seq_bit_counter #(
   parameter int CNT_W = 4
) (
   input  logic             sclk,
   input  logic             load_one,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);
   always_ff @(posedge sclk) begin
      if (load_one)  cnt <= CNT_W'(1);
      else if (inc)  cnt <= cnt + CNT_W'(1);
   end
endmodule

// File: rtl/seq_next_state.sv
module seq_next_state
   import spi_mem_seq_pkg::*;
#(
   parameter int CMD_BITS  = 8,
   parameter int DATA_BITS = 8,
   parameter int CNT_W     = 4
) (
   input  st_vec_t          st_q,
   input  logic [CNT_W-1:0] cnt,
   input  logic             ser_bit,
   output st_vec_t          st_d,
   output logic             load_one,
   output logic             inc
);
   localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_BITS);
   localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_BITS);

   always_comb begin
      st_d     = st_q;
      load_one = 1'b0;
      inc      = 1'b0;
      if (st_q[IX_START]) begin
         st_d     = ST_RECV;
         load_one = 1'b1;
      end else if (st_q[IX_RECV]) begin
         if (cnt == CMD_LAST) begin
            st_d     = ser_bit ? ST_READ0 : ST_WRITE;
            load_one = !ser_bit;
         end else begin
            inc = 1'b1;
         end
      end else if (st_q[IX_WRITE]) begin
         if (cnt == DATA_LAST) st_d = ST_END;
         else                  inc  = 1'b1;
      end else if (st_q[IX_READ0]) begin
         st_d     = ST_READ1;
         load_one = 1'b1;
      end else if (st_q[IX_READ1]) begin
         if (cnt == DATA_LAST) st_d = ST_END;
         else                  inc  = 1'b1;
      end
   end
endmodule

// File: rtl/seq_out_decode.sv
module seq_out_decode
   import spi_mem_seq_pkg::*;
#(
   parameter int CMD_BITS  = 8,
   parameter int DATA_BITS = 8,
   parameter int CNT_W     = 4
) (
   input  st_vec_t          st_q,
   input  logic [CNT_W-1:0] cnt,
   input  logic             cs_n,
   output logic             miso_oe,
   output logic             mem_we,
   output logic             addr_we,
   output logic             sr_load
);
   localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_BITS);
   localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_BITS);

   logic sel;
   assign sel     = !cs_n;
   assign addr_we = sel && st_q[IX_RECV]  && (cnt == CMD_LAST);
   assign mem_we  = sel && st_q[IX_WRITE] && (cnt == DATA_LAST);
   assign sr_load = sel && st_q[IX_READ0];
   assign miso_oe = sel && st_q[IX_READ1];
endmodule

// File: rtl/spi_mem_seq.sv
module spi_mem_seq
   import spi_mem_seq_pkg::*;
#(
   parameter int ADDR_W    = 7,
   parameter int CMD_BITS  = 8,
   parameter int DATA_BITS = 8
) (
   input  logic sclk,
   input  logic cs_n,
   input  logic ser_bit,
   output logic miso_oe,
   output logic mem_we,
   output logic addr_we,
   output logic sr_load
);
   localparam int MAX_BITS = (CMD_BITS > DATA_BITS) ? CMD_BITS : DATA_BITS;
   localparam int CNT_W    = $clog2(MAX_BITS + 1);

   if (ADDR_W + 1 != CMD_BITS) begin : g_bad_cmd
      $error("command word must hold the address plus one direction bit");
   end
   if (DATA_BITS < 1) begin : g_bad_data
      $error("data word must be at least one bit");
   end

   st_vec_t          st_q, st_d;
   logic [CNT_W-1:0] cnt;
   logic             load_one, inc;

   seq_state_reg u_state (
      .sclk(sclk), .cs_n(cs_n), .st_d(st_d), .st_q(st_q)
   );

   seq_bit_counter #(.CNT_W(CNT_W)) u_cnt (
      .sclk(sclk), .load_one(load_one), .inc(inc), .cnt(cnt)
   );

   seq_next_state #(.CMD_BITS(CMD_BITS), .DATA_BITS(DATA_BITS), .CNT_W(CNT_W)) u_next (
      .st_q(st_q), .cnt(cnt), .ser_bit(ser_bit),
      .st_d(st_d), .load_one(load_one), .inc(inc)
   );

   seq_out_decode #(.CMD_BITS(CMD_BITS), .DATA_BITS(DATA_BITS), .CNT_W(CNT_W)) u_out (
      .st_q(st_q), .cnt(cnt), .cs_n(cs_n),
      .miso_oe(miso_oe), .mem_we(mem_we), .addr_we(addr_we), .sr_load(sr_load)
   );
endmodule

// File: rtl/spi_mem_seq_chk.sv
module spi_mem_seq_chk #(
   parameter int DATA_BITS = 8
) (
   input logic sclk,
   input logic cs_n,
   input logic miso_oe,
   input logic mem_we,
   input logic addr_we,
   input logic sr_load
);
   localparam int RUN_W = $clog2(DATA_BITS + 2);
   logic [RUN_W-1:0] oe_run;

   always_ff @(posedge sclk) begin
      if (cs_n || !miso_oe) oe_run <= '0;
      else                  oe_run <= oe_run + RUN_W'(1);
   end

   // R1
   deselect_quiet_chk: assert property (@(posedge sclk)
      cs_n |-> !(miso_oe || mem_we || addr_we || sr_load));

   // R2
   addr_pulse_chk: assert property (@(posedge sclk) disable iff (cs_n)
      addr_we |=> !addr_we);

   // R4
   write_pulse_chk: assert property (@(posedge sclk) disable iff (cs_n)
      mem_we |=> !mem_we && !miso_oe && !sr_load);

   // R5
   load_then_drive_chk: assert property (@(posedge sclk) disable iff (cs_n)
      sr_load |=> miso_oe && !sr_load);

   // R5
   load_after_addr_chk: assert property (@(posedge sclk) disable iff (cs_n)
      $rose(sr_load) |-> $past(addr_we));

   // R6
   drive_window_chk: assert property (@(posedge sclk) disable iff (cs_n)
      miso_oe |-> (int'(oe_run) < DATA_BITS));

   // R9
   single_enable_chk: assert property (@(posedge sclk) disable iff (cs_n)
      $onehot0({miso_oe, mem_we, addr_we, sr_load}));
endmodule

bind spi_mem_seq spi_mem_seq_chk #(.DATA_BITS(DATA_BITS)) u_chk (
   .sclk(sclk), .cs_n(cs_n), .miso_oe(miso_oe), .mem_we(mem_we),
   .addr_we(addr_we), .sr_load(sr_load)
);

// File: tb/spi_mem_seq_tb_top.sv
module spi_mem_seq_tb_top;
   logic sclk = 1'b0;
   logic cs_n = 1'b1;
   logic ser_bit = 1'b0;
   logic miso_oe, mem_we, addr_we, sr_load;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #5 sclk = ~sclk;

   spi_mem_seq dut_i (
      .sclk(sclk), .cs_n(cs_n), .ser_bit(ser_bit),
      .miso_oe(miso_oe), .mem_we(mem_we), .addr_we(addr_we), .sr_load(sr_load)
   );

   // expected {miso_oe, mem_we, addr_we, sr_load} in the cycle after edge k
   function automatic logic [3:0] expect_en(int k, bit rd);
      if (k == 8) return 4'b0010;
      if (rd) begin
         if (k == 9) return 4'b0001;
         if (k >= 10 && k <= 17) return 4'b1000;
      end else begin
         if (k == 16) return 4'b0100;
      end
      return 4'b0000;
   endfunction

   function automatic string req_of(int k, bit rd);
      if (k < 8)  return "R8/R2";
      if (k == 8) return "R2";
      if (rd) begin
         if (k == 9)  return "R5/R3";
         if (k <= 17) return "R6";
         return "R7";
      end
      if (k <= 16) return "R4/R3";
      return "R7";
   endfunction

   task automatic check_en(logic [3:0] exp, string req);
      logic [3:0] act;
      act = {miso_oe, mem_we, addr_we, sr_load};
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: enables {oe,we,addr,load} actual %b expected %b", req, act, exp);
      end
      // R9: never more than one enable
      n_checks++;
      if ($countones(act) > 1) begin
         n_fail++;
         $display("FAIL R9: enables actual %b expected at most one set", act);
      end
   endtask

   // one transaction of nedges rising edges, then deselect
   task automatic run_txn(bit rd, int nedges, logic [15:0] pat);
      for (int k = 0; k <= nedges; k++) begin
         @(negedge sclk);
         if (k == 0) cs_n = 1'b0;
         // R3: only the bit presented for edge 9 selects direction
         ser_bit = (k == 8) ? rd : pat[k % 16];
         #1;
         check_en(expect_en(k, rd), req_of(k, rd));
      end
      @(negedge sclk);
      cs_n = 1'b1;
      ser_bit = pat[0];
      #1;
      // R1: deselect silences outputs at once
      check_en(4'b0000, "R1");
      @(negedge sclk);
      #1;
      check_en(4'b0000, "R1");
   endtask

   initial begin
      logic [15:0] pats [4];
      pats[0] = 16'h0000;
      pats[1] = 16'hFFFF;
      pats[2] = 16'h5555;
      pats[3] = 16'hC9B3;
      repeat (2) @(posedge sclk);
      #1;
      check_en(4'b0000, "R1");
      for (int d = 0; d < 2; d++) begin
         for (int p = 0; p < 4; p++) begin
            for (int n = 1; n <= 24; n++) begin
               run_txn(d[0], n, pats[p]);
            end
         end
      end
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         #(200000 * 10);
      join_any
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule